// File: doc/BRIEF.md
# Battery-Backed SRAM Strobe Controller

This block sits between a synchronous request port and an asynchronous, battery-backed byte-wide static memory of 2,097,152 locations. A single request carries a 21-bit address, a direction and a byte of write data. The controller turns it into the memory's active-low chip-enable, output-enable and write-enable strobes, with each phase held for a number of clock cycles set by parameters. It signals completion with a one-cycle done pulse. The memory data pins are modelled as a split bus: an outgoing byte, a drive-enable for the pad, and an incoming byte.

Two digital power-status inputs come from an external supervisor. The first reports that the supply is outside its tolerance band; while it is high, no write may reach the memory, but reads still complete. The second reports battery backup; while it is high, the memory is held deselected, the pad driver is off and no request is accepted. If either condition starts while a cycle it forbids is in progress, the strobes return high in that same cycle and the request completes with its error flag set.

A read holds all three enables for the longest of the address-access, chip-enable-access and output-enable-access counts before it samples the incoming byte. This longest count is worked out at elaboration.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset, all three memory strobes are high, the pad driver is off, no done pulse is present, and the request port is ready whenever battery backup is not reported.
- R2: During a read, chip enable and output enable are low, write enable is high, and the memory address equals the 21-bit request address latched when the request was accepted.
- R3: A read keeps its strobes low for exactly max(T_AA, T_CE, T_OE) cycles. It samples the incoming byte at the clock edge that ends the last of those cycles and returns that byte with done in the following cycle.
- R4: A write spends one cycle with chip enable low and write enable high. It then spends T_WP cycles with write enable also low, and the request byte is driven on the pad only in those T_WP cycles. Done follows in the next cycle.
- R5: Done is high for exactly one cycle per accepted request. The port is not ready from the cycle after acceptance until the cycle after done.
- R6: A write accepted while the out-of-tolerance input is high asserts no strobe and completes with done and error one cycle later. Memory contents are unchanged.
- R7: While the battery-backup input is high, chip enable, output enable and write enable are high, the pad driver is off, and the request port is not ready.
- R8: If battery backup starts during a read, or either power input goes high during a write, all strobes go high in that same cycle. Done with error follows in the next cycle.
- R9: Reads proceed normally and return correct data while the out-of-tolerance input is high.
- R10: The pad driver is never on while output enable is low. Output enable never falls in the cycle right after a cycle in which the pad driver was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused or aborted (valid with done) |
| rsp_rdata | output | 8 | Read byte (valid with done, no error) |
| pwr_low | input | 1 | Supply out of tolerance |
| pwr_batt | input | 1 | Battery backup active |
| mem_addr | output | 21 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte from the memory |

## Verification
The bench's memory model returns garbage until the chip-enable, output-enable and address ages have each reached their own count. A controller that samples one cycle early, or that waits only for the address time, therefore returns the wrong byte. Writes go directly into a read on the next request, so a pad driver left on into the read, or an output enable that falls too soon, is caught as contention. Power events arrive during the setup cycle, inside the write pulse and during a read. A design that waits for the phase to end before dropping the strobes would show a low chip enable while the power input is high. A design that lets a refused write reach the memory would change the byte that a later read returns.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_RESP   = 3'd4
  } seq_state_t;

  // longest of the three read access delays
  function automatic int unsigned wait_max(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // bits needed to hold a count value of (v - 1)
  function automatic int unsigned cnt_bits(input int unsigned v);
    if (v < 3) return 1;
    return $clog2(v);
  endfunction

  function automatic logic is_bus_state(input seq_state_t s);
    return (s == ST_READ) || (s == ST_WSETUP) || (s == ST_WPULSE);
  endfunction

endpackage

// File: rtl/nvsram_timer.sv
module nvsram_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvsram_pwr_guard.sv
module nvsram_pwr_guard
  import nvsram_pkg::*;
(
  input  seq_state_t st,
  input  logic       pwr_low,
  input  logic       pwr_batt,
  output logic       wr_block,
  output logic       desel,
  output logic       abort_now
);
  logic in_write;

  assign in_write  = (st == ST_WSETUP) || (st == ST_WPULSE);
  assign wr_block  = pwr_low | pwr_batt;
  assign desel     = pwr_batt;
  assign abort_now = ((st == ST_READ) && pwr_batt) || (in_write && wr_block);
endmodule

// File: rtl/nvsram_strobe.sv
module nvsram_strobe
  import nvsram_pkg::*;
(
  input  seq_state_t st,
  input  logic       abort_now,
  input  logic       desel,
  output logic       ce_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       dq_oe
);
  logic kill;

  assign kill  = abort_now | desel;
  assign ce_n  = !is_bus_state(st) || kill;
  assign oe_n  = (st != ST_READ)   || kill;
  assign we_n  = (st != ST_WPULSE) || kill;
  assign dq_oe = !we_n;
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_AA   = 4,
  parameter int unsigned T_CE   = 3,
  parameter int unsigned T_OE   = 2,
  parameter int unsigned T_WP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              pwr_low,
  input  logic              pwr_batt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RD_WAIT = wait_max(T_AA, T_CE, T_OE);
  localparam int unsigned CNT_MAX = (RD_WAIT > T_WP) ? RD_WAIT : T_WP;
  localparam int unsigned CNT_W   = cnt_bits(CNT_MAX);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(T_WP - 1);

  seq_state_t st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              err_q;

  // named events for the checker
  logic accept_evt, refuse_evt, abort_evt, sample_evt;
  logic wr_block, desel, t_expired, t_load;
  logic [CNT_W-1:0] t_val;

  assign req_ready  = (st_q == ST_IDLE) && !pwr_batt;
  assign accept_evt = req_valid && req_ready;
  assign refuse_evt = accept_evt && req_write && wr_block;
  assign sample_evt = (st_q == ST_READ) && t_expired && !abort_evt;

  nvsram_pwr_guard u_guard (
    .st        (st_q),
    .pwr_low   (pwr_low),
    .pwr_batt  (pwr_batt),
    .wr_block  (wr_block),
    .desel     (desel),
    .abort_now (abort_evt)
  );

  assign t_load = (accept_evt && !req_write) ||
                  ((st_q == ST_WSETUP) && !abort_evt);
  assign t_val  = (st_q == ST_WSETUP) ? WP_LOAD : RD_LOAD;

  nvsram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_evt) begin
          if (!req_write)    st_d = ST_READ;
          else if (wr_block) st_d = ST_RESP;
          else               st_d = ST_WSETUP;
        end
      end
      ST_READ:   if (abort_evt || t_expired) st_d = ST_RESP;
      ST_WSETUP: st_d = abort_evt ? ST_RESP : ST_WPULSE;
      ST_WPULSE: if (abort_evt || t_expired) st_d = ST_RESP;
      ST_RESP:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept_evt) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        err_q   <= refuse_evt;
      end else if (abort_evt) begin
        err_q   <= 1'b1;
      end
      if (sample_evt) rdata_q <= mem_dq_in;
    end
  end

  nvsram_strobe u_strobe (
    .st        (st_q),
    .abort_now (abort_evt),
    .desel     (desel),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_done   = (st_q == ST_RESP);
  assign rsp_err    = err_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/nvsram_ctrl_sva.sv
module nvsram_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic pwr_low,
  input logic pwr_batt,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_oe,
  input logic rsp_done,
  input logic rsp_err,
  input logic abort_evt
);
  a_r7_batt_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_batt |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready));

  a_r6_low_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_low |-> mem_we_n);

  a_r6_refuse_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && pwr_low) |=> (rsp_done && rsp_err));

  a_r8_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (rsp_done && rsp_err));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r4_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  a_r10_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
endmodule

bind nvsram_ctrl nvsram_ctrl_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .pwr_low   (pwr_low),
  .pwr_batt  (pwr_batt),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .abort_evt (abort_evt)
);

// File: tb/nvsram_ctrl_bench.sv
module nvsram_ctrl_bench;
  localparam int T_AA = 4, T_CE = 3, T_OE = 2, T_WP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic pwr_low = 1'b0, pwr_batt = 1'b0;
  logic req_ready, rsp_done, rsp_err, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = 8'hA5;
  logic [20:0] mem_addr;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  nvsram_ctrl #(.T_AA(T_AA), .T_CE(T_CE), .T_OE(T_OE), .T_WP(T_WP)) u_nvsram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .pwr_low(pwr_low), .pwr_batt(pwr_batt), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // ---------------- memory model with access ages ----------------
  logic [7:0] mem [int];
  function automatic logic [7:0] mem_get(input int a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'h3C;
  endfunction

  // ---------------- reference model ----------------
  int mode = 0;       // 0 idle, 1 read, 2 write setup, 3 write pulse, 4 response
  int left = 0;
  int rd_wait;
  bit m_err = 0, m_read = 0;
  logic [20:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rdata = '0;

  initial rd_wait = (T_AA > T_CE ? T_AA : T_CE) > T_OE ? (T_AA > T_CE ? T_AA : T_CE) : T_OE;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; m_err = 0;
    end else begin
      case (mode)
        0: if (req_valid && !pwr_batt) begin
             m_addr = req_addr; m_wdata = req_wdata; m_read = !req_write;
             if (!req_write) begin mode = 1; left = rd_wait - 1; m_err = 0; end
             else if (pwr_low) begin mode = 4; m_err = 1; end
             else begin mode = 2; m_err = 0; end
           end
        1: if (pwr_batt) begin mode = 4; m_err = 1; end
           else if (left == 0) begin mode = 4; m_rdata = mem_get(int'(m_addr)); end
           else left--;
        2: if (pwr_batt || pwr_low) begin mode = 4; m_err = 1; end
           else begin mode = 3; left = T_WP - 1; end
        3: if (pwr_batt || pwr_low) begin mode = 4; m_err = 1; end
           else if (left == 0) mode = 4;
           else left--;
        default: mode = 0;
      endcase
    end
  end

  task automatic cmp(input string fld, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h at %0t", tag, fld, got, exp, $time);
    end
  endtask

  int ce_age = 0, oe_age = 0, ad_age = 0;
  logic [20:0] prev_addr = '0;
  logic prev_dq_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit ab;
      logic e_ce, e_oe, e_we;
      ab   = (mode == 1 && pwr_batt) || ((mode == 2 || mode == 3) && (pwr_low || pwr_batt));
      e_ce = !(mode >= 1 && mode <= 3) || ab || pwr_batt;
      e_oe = (mode != 1) || ab || pwr_batt;
      e_we = (mode != 3) || ab || pwr_batt;
      cmp("ce_n(R2)", mem_ce_n, e_ce);
      cmp("oe_n(R2)", mem_oe_n, e_oe);
      cmp("we_n(R4)", mem_we_n, e_we);
      cmp("dq_oe(R4)", mem_dq_oe, !e_we);
      cmp("ready(R5)", req_ready, (mode == 0) && !pwr_batt);
      cmp("done(R5)", rsp_done, mode == 4);
      if (mode == 4) cmp("err(R8)", rsp_err, m_err);
      if (mode == 4 && m_read && !m_err) cmp("rdata(R3)", rsp_rdata, m_rdata);
      if (!e_ce) cmp("addr(R2)", mem_addr, m_addr);
      if (!e_we) cmp("wdata(R4)", mem_dq_out, m_wdata);
      // R10: no contention and a dead cycle before output enable
      checks++;
      if ((mem_dq_oe && !mem_oe_n) || (prev_dq_oe && !mem_oe_n)) begin
        errors++;
        $display("FAIL R10 turnaround got dq_oe=%b prev=%b oe_n=%b exp no overlap",
                 mem_dq_oe, prev_dq_oe, mem_oe_n);
      end
    end
    prev_dq_oe = mem_dq_oe;
    // memory side
    ce_age = !mem_ce_n ? ce_age + 1 : 0;
    oe_age = (!mem_ce_n && !mem_oe_n) ? oe_age + 1 : 0;
    ad_age = (mem_addr == prev_addr) ? ad_age + 1 : 1;
    prev_addr = mem_addr;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;
    if (!mem_ce_n && !mem_oe_n && ce_age >= T_CE && oe_age >= T_OE && ad_age >= T_AA)
      mem_dq_in = mem_get(int'(mem_addr));
    else
      mem_dq_in = 8'hA5;
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input logic [20:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 40; i++) begin
      if (mode == 0) break;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got hang exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    tag = "R1";
    cmp("reset ce_n", mem_ce_n, 1'b1);
    cmp("reset oe_n", mem_oe_n, 1'b1);
    cmp("reset we_n", mem_we_n, 1'b1);
    cmp("reset done", rsp_done, 1'b0);
    cmp("reset ready", req_ready, 1'b1);

    // R4 writes at edge addresses, R3 reads back, R2 read strobes
    tag = "R4"; issue(1, 21'h000000, 8'h11); settle();
    issue(1, 21'h1FFFFF, 8'hEE); settle();
    issue(1, 21'h0ABCDE, 8'h5A); settle();
    tag = "R3"; issue(0, 21'h000000, 8'h00); settle();
    issue(0, 21'h1FFFFF, 8'h00); settle();
    tag = "R2"; issue(0, 21'h0ABCDE, 8'h00); settle();
    issue(0, 21'h123456, 8'h00); settle();   // unwritten location

    // R10 write straight into read, R5 back-to-back handshakes
    tag = "R10"; issue(1, 21'h000777, 8'hC3); issue(0, 21'h000777, 8'h00); settle();
    tag = "R5";  issue(0, 21'h1FFFFF, 8'h00); issue(0, 21'h000000, 8'h00); settle();

    // R9 read while supply out of tolerance; R6 write refused
    @(posedge clk); #1 pwr_low = 1'b1;
    tag = "R9"; issue(0, 21'h0ABCDE, 8'h00); settle();
    tag = "R6"; issue(1, 21'h0ABCDE, 8'h99); settle();
    @(posedge clk); #1 pwr_low = 1'b0;
    issue(0, 21'h0ABCDE, 8'h00); settle();   // still 5A

    // R7 battery backup: nothing accepted, everything deselected
    tag = "R7";
    @(posedge clk); #1 pwr_batt = 1'b1; req_valid = 1'b1; req_write = 1'b0;
    repeat (5) @(posedge clk);
    #1 req_valid = 1'b0; pwr_batt = 1'b0;
    settle();

    // R8 aborts: read hit by backup, write hit in setup and in pulse
    tag = "R8";
    @(posedge clk); #1; req_valid = 1; req_write = 0; req_addr = 21'h000010;
    @(posedge clk); #1; req_valid = 0;
    @(posedge clk); #1; pwr_batt = 1;
    @(posedge clk); #1; pwr_batt = 0; settle();
    @(posedge clk); #1; req_valid = 1; req_write = 1; req_addr = 21'h000020; req_wdata = 8'h77;
    @(posedge clk); #1; req_valid = 0; pwr_low = 1;
    @(posedge clk); #1; pwr_low = 0; settle();
    @(posedge clk); #1; req_valid = 1; req_write = 1; req_addr = 21'h000030; req_wdata = 8'h66;
    @(posedge clk); #1; req_valid = 0;
    @(posedge clk); #1; pwr_batt = 1;
    @(posedge clk); #1; pwr_batt = 0; settle();
    tag = "R6"; issue(0, 21'h000020, 8'h00); settle();  // untouched by aborted setup

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule